// File: doc/BRIEF.md
# I/O Expander Port Mode Register Bank

This block holds the pin-mode settings and the output latches for an I/O expander with 28 ports, numbered 4 to 31. Seven byte-wide mode registers each carry four ports as 2-bit mode codes. A simple bus-side interface gives register writes and combinational reads through an address, write data, write strobe and read data. For each port the block produces an output enable, an output level and a pullup enable. It also synchronizes the pin input so that the bus can read it.

Each port also has a data register at its own byte address. A write to it sets the port's output latch from data bit 0. A read returns the latch when the port is an output and the synchronized pin level otherwise. The pads, the input buffers and the serial bus front end sit outside this block. Port bit k on every vector belongs to port k+4.

Top module: `pmc_port_bank`

## Requirements
- R1: After reset every mode register reads 0xAA, all output enables, pullup enables and output levels are 0, and every output latch is 0.
- R2: Mode registers sit at 0x09 (ports 4-7) through 0x0F (ports 28-31). A write stores the whole byte and a read returns it exactly. Bits 1:0 hold the lowest-numbered port of the register, then 3:2, 5:4, and 7:6 the highest.
- R3: Mode code 01 is push-pull output. The port's output enable is 1 and its output level equals its latch.
- R4: Mode code 10 is input without pullup. The output enable, the pullup enable and the output level are 0.
- R5: Mode code 11 is input with pullup. The pullup enable is 1, and the output enable and output level are 0. No port ever has output enable and pullup enable high together.
- R6: Mode code 00 is reserved. It is stored and read back as written, but the port behaves exactly as with code 10.
- R7: The data register of port n is at address 0x20+n (0x24 to 0x3F). A write sets the port's latch from bit 0 in any mode. A read returns {7'b0, latch} when the port is in mode 01.
- R8: A read of a data register in any mode other than 01 returns {7'b0, pin}. The pin value is taken through two flops, so a pin change shows on the read data after the second rising clock edge and not after the first.
- R9: A write to any address outside 0x09-0x0F and 0x24-0x3F changes no register. A read of such an address returns 0x00.
- R10: Register writes take effect on the rising edge at which the write strobe is sampled high. Before that edge the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pin_i | input | 28 | Pin levels from the input buffers, bit k is port k+4 |
| pin_oe_o | output | 28 | Output enable per port |
| pin_out_o | output | 28 | Output level per port |
| pin_pu_o | output | 28 | Pullup enable per port |

## Verification
The assertions assume that the write strobe, address and data are stable around the rising edge. They also assume that pin inputs change only between edges, so the synchronizer checks can compare the second flop with the pin two cycles earlier. The bench drives every input on the falling edge and samples outputs one time unit after it, which keeps all changes away from the active edge. It sweeps every mode code through every field of every mode register and checks all 28 ports against a model computed in the bench from the code and latch arithmetic.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RSVD  = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_IN    = 2'b10,
    MODE_IN_PU = 2'b11
  } port_mode_e;

  localparam logic [7:0] CFG_RST = 8'hAA;  // all ports input, no pullup
endpackage

// File: rtl/pmc_cfg_bank.sv
module pmc_cfg_bank #(
  parameter int NUM_REGS = 7,
  parameter int ADDR_W   = 8,
  parameter int CFG_BASE = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  we_i,
  output logic [NUM_REGS*8-1:0] cfg_o,
  output logic                  hit_o,
  output logic [7:0]            rdata_o
);
  logic [NUM_REGS-1:0] sel;
  logic [7:0]          regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign sel[g] = (addr_i == ADDR_W'(CFG_BASE + g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            regs_q[g] <= pmc_pkg::CFG_RST;
      else if (we_i && sel[g]) regs_q[g] <= wdata_i;
    end

    assign cfg_o[g*8 +: 8] = regs_q[g];

    // R2
    wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel[g]) |=> (regs_q[g] == $past(wdata_i)));
  end

  assign hit_o = |sel;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) rdata_o = regs_q[i];
  end

  // R9
  miss_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_o) |=> $stable(cfg_o));
endmodule

// File: rtl/pmc_port_cell.sv
module pmc_port_cell (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       wr_i,
  input  logic       wbit_i,
  input  logic       pin_i,
  output logic       oe_o,
  output logic       out_o,
  output logic       pu_o,
  output logic       rd_bit_o
);
  import pmc_pkg::*;

  port_mode_e mode;
  logic       latch_q;
  logic [1:0] sync_q;
  logic [1:0] age_q;

  assign mode = port_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      sync_q  <= '0;
      age_q   <= '0;
    end else begin
      if (wr_i) latch_q <= wbit_i;
      sync_q <= {sync_q[0], pin_i};
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  // reserved code falls back to plain input
  always_comb begin
    oe_o = 1'b0;
    pu_o = 1'b0;
    unique case (mode)
      MODE_OUT:   oe_o = 1'b1;
      MODE_IN_PU: pu_o = 1'b1;
      default:    ;
    endcase
  end

  assign out_o    = oe_o & latch_q;
  assign rd_bit_o = oe_o ? latch_q : sync_q[1];

  // R10
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(latch_q));

  // R8
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_q[1] == $past(pin_i, 2)));
endmodule

// File: rtl/pmc_port_bank.sv
module pmc_port_bank #(
  parameter int NUM_PORTS  = 28,
  parameter int FIRST_PORT = 4,
  parameter int ADDR_W     = 8,
  parameter int CFG_BASE   = 9,
  parameter int DATA_BASE  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 we_i,
  output logic [7:0]           rdata_o,
  input  logic [NUM_PORTS-1:0] pin_i,
  output logic [NUM_PORTS-1:0] pin_oe_o,
  output logic [NUM_PORTS-1:0] pin_out_o,
  output logic [NUM_PORTS-1:0] pin_pu_o
);
  localparam int NUM_REGS = NUM_PORTS / 4;

  logic [NUM_REGS*8-1:0] cfg;
  logic                  cfg_hit;
  logic [7:0]            cfg_rdata;
  logic [NUM_PORTS-1:0]  dsel;
  logic [NUM_PORTS-1:0]  rd_bit;

  pmc_cfg_bank #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .CFG_BASE (CFG_BASE)
  ) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .cfg_o   (cfg),
    .hit_o   (cfg_hit),
    .rdata_o (cfg_rdata)
  );

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    assign dsel[k] = (addr_i == ADDR_W'(DATA_BASE + FIRST_PORT + k));

    pmc_port_cell i_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (cfg[2*k +: 2]),
      .wr_i     (we_i & dsel[k]),
      .wbit_i   (wdata_i[0]),
      .pin_i    (pin_i[k]),
      .oe_o     (pin_oe_o[k]),
      .out_o    (pin_out_o[k]),
      .pu_o     (pin_pu_o[k]),
      .rd_bit_o (rd_bit[k])
    );
  end

  assign rdata_o = cfg_hit ? cfg_rdata : {7'b0, |(dsel & rd_bit)};

  // R5
  oe_pu_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pin_pu_o) == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_oe_o == '0 && pin_pu_o == '0 && pin_out_o == '0));
endmodule

// File: tb/test_pmc_port_bank.sv
module test_pmc_port_bank;
  localparam int CLK_P = 10;
  localparam int NP = 28;
  localparam int NR = 7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [7:0]    addr = 0, wdata = 0, rdata;
  logic          we = 0;
  logic [NP-1:0] pin = 0, oe, pout, pu;

  int n_run = 0, n_fail = 0;
  logic [7:0] cfg_m [NR];
  logic [NP-1:0] lat_m;

  always #(CLK_P/2) clk = ~clk;

  pmc_port_bank i_pmc_port_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pin_i(pin), .pin_oe_o(oe), .pin_out_o(pout), .pin_pu_o(pu)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
    #1;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, {24'b0, rdata}, {24'b0, exp});
  endtask

  function automatic logic [1:0] mode_of(int k);
    return 2'((cfg_m[k/4] >> (2*(k%4))) & 8'h3);
  endfunction

  task automatic port_chk(string tag);
    logic [NP-1:0] e_oe, e_out, e_pu;
    for (int k = 0; k < NP; k++) begin
      e_oe[k]  = (mode_of(k) == 2'b01);
      e_pu[k]  = (mode_of(k) == 2'b11);
      e_out[k] = e_oe[k] & lat_m[k];
    end
    check({tag, " oe"}, 32'(oe), 32'(e_oe));
    check({tag, " pu"}, 32'(pu), 32'(e_pu));
    check({tag, " out"}, 32'(pout), 32'(e_out));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) cfg_m[r] = 8'hAA;
    lat_m = '0;
    #(CLK_P * 3) rst_n = 1;
    #1;
    // R1 reset state
    port_chk("R1");
    for (int r = 0; r < NR; r++) rd_chk("R1 cfg", 8'(9 + r), 8'hAA);

    // R2..R6 sweep every code through every field of every register
    for (int r = 0; r < NR; r++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 4; c++) begin
          logic [7:0] b;
          b = 8'h1B ^ 8'(r * 37);
          b[2*s +: 2] = 2'(c);
          wr(8'(9 + r), b);
          cfg_m[r] = b;
          case (c)
            0: port_chk("R6");
            1: port_chk("R3");
            2: port_chk("R4");
            default: port_chk("R5");
          endcase
          rd_chk("R2", 8'(9 + r), b);
        end

    // R7 latches with all ports in output mode
    for (int r = 0; r < NR; r++) begin wr(8'(9 + r), 8'h55); cfg_m[r] = 8'h55; end
    for (int k = 0; k < NP; k++) begin
      wr(8'(36 + k), 8'((k % 3 == 0) ? 8'hFF : 8'hFE));
      lat_m[k] = (k % 3 == 0);
    end
    port_chk("R7 R3");
    for (int k = 0; k < NP; k++) rd_chk("R7", 8'(36 + k), {7'b0, lat_m[k]});

    // R10 write not visible before the sampling edge
    @(negedge clk);
    addr = 8'h09; wdata = 8'hAA; we = 1;
    #1;
    port_chk("R10 pre");
    @(negedge clk);
    we = 0; cfg_m[0] = 8'hAA;
    #1;
    port_chk("R10 post");

    // R7 latch written in input mode still stored
    wr(8'h24, 8'h00); lat_m[0] = 0;
    wr(8'h09, 8'h01); cfg_m[0] = 8'h01;
    port_chk("R7 input-mode write");

    // R8 synchronized pin reads; modes 10, 11, 00
    wr(8'h09, 8'hAA); cfg_m[0] = 8'hAA;
    wr(8'h0A, 8'hFF); cfg_m[1] = 8'hFF;
    wr(8'h0B, 8'h00); cfg_m[2] = 8'h00;
    for (int p = 0; p < 3; p++) begin
      logic [NP-1:0] pv;
      pv = (p == 0) ? 28'h5A5A5A5 : (p == 1) ? 28'hA5A5A5A : 28'hFFFFFFF;
      @(negedge clk); pin = pv;
      @(negedge clk); @(negedge clk);
      for (int k = 0; k < 12; k++)
        rd_chk("R8", 8'(36 + k), {7'b0, pv[k]});
    end
    @(negedge clk); addr = 8'h24; pin[0] = 0;
    @(negedge clk); #1;
    check("R8 one edge", 32'(rdata), 32'h1);
    @(negedge clk); #1;
    check("R8 two edges", 32'(rdata), 32'h0);

    // R9 unmapped addresses
    foreach (cfg_m[r]) rd_chk("R9 pre", 8'(9 + r), cfg_m[r]);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h08 : (i == 1) ? 8'h10 : (i == 2) ? 8'h23 :
          (i == 3) ? 8'h40 : (i == 4) ? 8'h20 : 8'hFF;
      wr(a, 8'h01);
      rd_chk("R9 read", a, 8'h00);
    end
    port_chk("R9 ports");
    for (int r = 0; r < NR; r++) rd_chk("R9 cfg", 8'(9 + r), cfg_m[r]);

    // R1 reset again restores defaults
    @(negedge clk); rst_n = 0;
    for (int r = 0; r < NR; r++) cfg_m[r] = 8'hAA;
    lat_m = '0;
    @(negedge clk); rst_n = 1; #1;
    port_chk("R1 rerst");
    for (int r = 0; r < NR; r++) wr(8'(9 + r), 8'h55);
    for (int r = 0; r < NR; r++) cfg_m[r] = 8'h55;
    port_chk("R1 latches zero");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule